// File: doc/BRIEF.md
# Linear Page Table Translation Unit

This unit turns a processor's virtual address into a physical address. It uses a single-level page table that sits in memory. The table is a flat array of 32-bit entries, and the virtual page number indexes it directly. A length register bounds the array. A base register gives the array's address in memory. Only privileged configuration writes can change either register.

A request carries a virtual address and an access type, read or write. The unit checks the page number against the length. For an in-range page it fetches the entry through a simple memory read port and checks validity and permission. It then answers with either a physical address or a fault with a two-bit cause. On a successful access the unit sets the entry's referenced bit, and on a write it also sets the dirty bit. The entry goes back to memory only when one of those bits actually changed.

Pages are 4096 bytes. The low 12 bits of the address pass through unchanged. The unit handles one request at a time. A response appears as a one-cycle pulse.

Top module: `ptx_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0. Base and length are both 0, so the first request faults with cause 0.
- R2: A successful response gives `rsp_pa` = entry bits [31:12] concatenated with request VA bits [11:0]. A faulting response gives `rsp_pa` = 0.
- R3: An in-range request issues exactly one entry read, at address base + 4 × page number, where the page number is VA bits [31:12].
- R4: A page number greater than or equal to the length faults with cause 0 and makes no memory access. Its response appears in the first cycle after acceptance.
- R5: An entry with bit 0 (valid) clear faults with cause 1, whatever its permission bits hold.
- R6: A read of a valid entry with bit 1 (readable) clear faults with cause 2. A write of a valid entry with bit 2 (writeable) clear faults with cause 3. A write does not need bit 1.
- R7: A successful access sets bit 3 (referenced), and a write also sets bit 4 (dirty). All other bits are kept as they were.
- R7 (continued): The updated entry is written to the address it was read from, in the cycle just before the response, and only if bit 3 or bit 4 went from 0 to 1.
- R8: A faulting access never writes the entry.
- R9: A configuration write with `cfg_priv` = 1 loads the base when `cfg_sel` = 0, and loads the length (low 21 bits) when `cfg_sel` = 1. With `cfg_priv` = 0 the write is ignored.
- R10: `req_ready` is 1 only when the unit is idle. `rsp_valid` stays high for exactly one cycle.
- R10 (continued): For a walked request, `rsp_valid` rises in the cycle after the one in which `mem_rd_valid` is seen, or one cycle later if a write-back is needed.
- R11: `rsp_va` returns the virtual address of the request being answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Requester is privileged |
| cfg_sel | input | 1 | 0 selects base, 1 selects length |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_va | input | 32 | Virtual address |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| mem_rd_en | output | 1 | Entry read request, one cycle |
| mem_rd_addr | output | 32 | Entry byte address |
| mem_rd_valid | input | 1 | Read data valid, at least one cycle after the read request |
| mem_rd_data | input | 32 | Entry read data |
| mem_wr_en | output | 1 | Entry write-back, one cycle |
| mem_wr_addr | output | 32 | Write-back byte address |
| mem_wr_data | output | 32 | Updated entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 2 | Fault cause: 0 range, 1 invalid, 2 read denied, 3 write denied |
| rsp_va | output | 32 | Virtual address of the answered request |
| rsp_pa | output | 32 | Physical address, 0 on fault |

## Verification
Corrupted internal state shows up at the ports within one transaction. A latched access type or base that is wrong produces a wrong read address, a wrong cause, or a wrong write-back image, and these appear in the same walk. A broken length compare is visible on the very next request, either as a memory read that should not happen or as a range fault that should not happen. A sequencing fault shifts the response by a cycle against the memory return. The bench model compares every response, read address, memory image and latency against values it computes from its own copy of the configuration and the memory contents.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
    localparam int OFF_W       = 12;
    localparam int PTE_W       = 32;
    localparam int PTE_PPN_LSB = 12;
    localparam int BIT_VALID   = 0;
    localparam int BIT_READ    = 1;
    localparam int BIT_WRITE   = 2;
    localparam int BIT_REF     = 3;
    localparam int BIT_DIRTY   = 4;

    typedef enum logic [1:0] {
        CAUSE_RANGE   = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_NOREAD  = 2'd2,
        CAUSE_NOWRITE = 2'd3
    } fault_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WAIT = 3'd2,
        ST_WB   = 3'd3,
        ST_DONE = 3'd4
    } walk_state_e;
endpackage

// File: rtl/ptx_cfg_regs.sv
module ptx_cfg_regs #(
    parameter int MA_W  = 32,
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic             cfg_sel,
    input  logic [MA_W-1:0]  cfg_wdata,
    output logic [MA_W-1:0]  base_q,
    output logic [LEN_W-1:0] len_q
);
    typedef struct packed {
        logic [MA_W-1:0]  base;
        logic [LEN_W-1:0] len;
    } cfg_t;

    cfg_t r_d, r_q;

    // Privilege gate: user-mode writes leave both registers untouched (R9)
    always_comb begin
        r_d = r_q;
        if (cfg_we && cfg_priv) begin
            if (cfg_sel) r_d.len  = cfg_wdata[LEN_W-1:0];
            else         r_d.base = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_q = r_q.base;
    assign len_q  = r_q.len;
endmodule

// File: rtl/ptx_addr_gen.sv
module ptx_addr_gen #(
    parameter int VPN_W = 20,
    parameter int MA_W  = 32,
    parameter int LEN_W = 21
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [MA_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    output logic             in_range,
    output logic [MA_W-1:0]  ent_addr
);
    localparam int ENT_SHIFT = $clog2(ptx_pkg::PTE_W / 8);

    assign in_range = LEN_W'(vpn) < len;
    assign ent_addr = base + (MA_W'(vpn) << ENT_SHIFT);
endmodule

// File: rtl/ptx_pte_eval.sv
module ptx_pte_eval
    import ptx_pkg::*;
(
    input  logic             is_write,
    input  logic [PTE_W-1:0] pte,
    output logic             fault,
    output fault_cause_e     cause,
    output logic [PTE_W-1:0] pte_upd,
    output logic             need_wb
);
    always_comb begin
        fault = 1'b0;
        cause = CAUSE_INVALID;
        if (!pte[BIT_VALID]) begin
            fault = 1'b1;
            cause = CAUSE_INVALID;
        end else if (!is_write && !pte[BIT_READ]) begin
            fault = 1'b1;
            cause = CAUSE_NOREAD;
        end else if (is_write && !pte[BIT_WRITE]) begin
            fault = 1'b1;
            cause = CAUSE_NOWRITE;
        end

        pte_upd          = pte;
        pte_upd[BIT_REF] = 1'b1;
        if (is_write) pte_upd[BIT_DIRTY] = 1'b1;
        need_wb = !fault && (pte_upd != pte);
    end
endmodule

// File: rtl/ptx_unit.sv
module ptx_unit
    import ptx_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int MA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_priv,
    input  logic                      cfg_sel,
    input  logic [MA_W-1:0]           cfg_wdata,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [VPN_W+OFF_W-1:0]    req_va,
    output logic                      req_ready,
    output logic                      mem_rd_en,
    output logic [MA_W-1:0]           mem_rd_addr,
    input  logic                      mem_rd_valid,
    input  logic [PTE_W-1:0]          mem_rd_data,
    output logic                      mem_wr_en,
    output logic [MA_W-1:0]           mem_wr_addr,
    output logic [PTE_W-1:0]          mem_wr_data,
    output logic                      rsp_valid,
    output logic                      rsp_fault,
    output logic [1:0]                rsp_cause,
    output logic [VPN_W+OFF_W-1:0]    rsp_va,
    output logic [PTE_W-PTE_PPN_LSB+OFF_W-1:0] rsp_pa
);
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PPN_W = PTE_W - PTE_PPN_LSB;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int LEN_W = VPN_W + 1;

    typedef struct packed {
        walk_state_e     st;
        logic [VA_W-1:0] va;
        logic            wr;
        logic [MA_W-1:0] ent;
        logic [PTE_W-1:0] pte;
        logic            fault;
        fault_cause_e    cause;
        logic [PA_W-1:0] pa;
    } walk_t;

    walk_t w_d, w_q;

    logic [MA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;
    logic             in_range;
    logic [MA_W-1:0]  ent_addr;
    logic             ev_fault;
    fault_cause_e     ev_cause;
    logic [PTE_W-1:0] pte_upd;
    logic             need_wb;

    ptx_cfg_regs #(.MA_W(MA_W), .LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_priv (cfg_priv),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .base_q   (base_q),
        .len_q    (len_q)
    );

    ptx_addr_gen #(.VPN_W(VPN_W), .MA_W(MA_W), .LEN_W(LEN_W)) u_agen (
        .vpn     (req_va[VA_W-1:OFF_W]),
        .base    (base_q),
        .len     (len_q),
        .in_range(in_range),
        .ent_addr(ent_addr)
    );

    ptx_pte_eval u_eval (
        .is_write(w_q.wr),
        .pte     (mem_rd_data),
        .fault   (ev_fault),
        .cause   (ev_cause),
        .pte_upd (pte_upd),
        .need_wb (need_wb)
    );

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.va  = req_va;
                    w_d.wr  = req_write;
                    w_d.ent = ent_addr;
                    w_d.pa  = '0;
                    if (in_range) begin
                        w_d.st    = ST_RD;
                        w_d.fault = 1'b0;
                    end else begin
                        w_d.st    = ST_DONE;
                        w_d.fault = 1'b1;
                        w_d.cause = CAUSE_RANGE;
                    end
                end
            end
            ST_RD:   w_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    w_d.pte = pte_upd;
                    if (ev_fault) begin
                        w_d.fault = 1'b1;
                        w_d.cause = ev_cause;
                        w_d.st    = ST_DONE;
                    end else begin
                        w_d.pa = {mem_rd_data[PTE_W-1:PTE_PPN_LSB], w_q.va[OFF_W-1:0]};
                        w_d.st = need_wb ? ST_WB : ST_DONE;
                    end
                end
            end
            ST_WB:   w_d.st = ST_DONE;
            ST_DONE: w_d.st = ST_IDLE;
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready   = (w_q.st == ST_IDLE);
    assign mem_rd_en   = (w_q.st == ST_RD);
    assign mem_rd_addr = w_q.ent;
    assign mem_wr_en   = (w_q.st == ST_WB);
    assign mem_wr_addr = w_q.ent;
    assign mem_wr_data = w_q.pte;
    assign rsp_valid   = (w_q.st == ST_DONE);
    assign rsp_fault   = w_q.fault;
    assign rsp_cause   = w_q.cause;
    assign rsp_va      = w_q.va;
    assign rsp_pa      = w_q.pa;
endmodule

// File: rtl/ptx_unit_chk.sv
module ptx_unit_chk #(
    parameter int VA_W = 32,
    parameter int MA_W = 32,
    parameter int PA_W = 32,
    parameter int PTE_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_rd_en,
    input logic [MA_W-1:0]  mem_rd_addr,
    input logic             mem_wr_en,
    input logic [MA_W-1:0]  mem_wr_addr,
    input logic [PTE_W-1:0] mem_wr_data,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause,
    input logic [VA_W-1:0]  rsp_va,
    input logic [PA_W-1:0]  rsp_pa
);
    logic [MA_W-1:0] last_rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         last_rd_q <= '0;
        else if (mem_rd_en) last_rd_q <= mem_rd_addr;
    end

    a_r10_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en || rsp_valid) |-> !req_ready);
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    a_r8_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !$past(mem_wr_en));
    a_r7_wb_before_ok: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (rsp_valid && !rsp_fault));
    a_r7_wb_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wr_data[3]);
    a_r7_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_addr == last_rd_q));
    a_r4_range_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_cause == 2'd0) |-> $past(req_ready));
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[11:0] == rsp_va[11:0]));
    a_r2_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
endmodule

bind ptx_unit ptx_unit_chk #(
    .VA_W (VA_W),
    .MA_W (MA_W),
    .PA_W (PA_W),
    .PTE_W(ptx_pkg::PTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_cause  (rsp_cause),
    .rsp_va     (rsp_va),
    .rsp_pa     (rsp_pa)
);

// File: tb/ptx_unit_tb.sv
`timescale 1ns/1ps
module ptx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_va, rsp_pa;

    always #2 clk = ~clk;

    ptx_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_va(req_va), .req_ready(req_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_va(rsp_va), .rsp_pa(rsp_pa)
    );

    // Behavioural memory: 1024 words, byte address bits [11:2]
    logic [31:0] mem [0:1023];
    logic        poke_en = 1'b0;
    logic [9:0]  poke_idx = '0;
    logic [31:0] poke_dat = '0;
    int          mem_extra = 0;
    logic        pend = 1'b0;
    int          pend_cnt = 0;
    logic [9:0]  pend_idx = '0;

    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
    end

    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (poke_en)   mem[poke_idx] <= poke_dat;
        if (mem_wr_en) mem[mem_wr_addr[11:2]] <= mem_wr_data;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[pend_idx];
                pend         <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end else if (mem_rd_en) begin
            if (mem_extra == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[mem_rd_addr[11:2]];
            end else begin
                pend     <= 1'b1;
                pend_cnt <= mem_extra - 1;
                pend_idx <= mem_rd_addr[11:2];
            end
        end
    end

    // Port monitor: counts memory operations and records the last read address
    int          rd_total = 0, wr_total = 0;
    logic [31:0] last_rd_addr = '0;
    always @(negedge clk) begin
        if (mem_rd_en) begin
            rd_total     <= rd_total + 1;
            last_rd_addr <= mem_rd_addr;
        end
        if (mem_wr_en) wr_total <= wr_total + 1;
    end

    int n_checks = 0, n_fails = 0;
    logic [31:0] base_m = '0;
    logic [20:0] len_m  = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = addr[11:2]; poke_dat = data;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic cfg(input bit priv, input bit sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
        if (priv) begin
            if (sel) len_m  = data[20:0];
            else     base_m = data;
        end
    endtask

    task automatic xlate(input logic [31:0] va, input bit wr, input int extra);
        logic [19:0] vpn;
        logic [31:0] ent, old, upd, exp_pa;
        bit          oob, flt, wb, busy_ready;
        logic [1:0]  cse;
        int          exp_lat, lat, rd0, wr0;
        vpn = va[31:12];
        ent = base_m + {10'd0, vpn, 2'b00};
        old = mem[ent[11:2]];
        oob = ({1'b0, vpn} >= len_m);
        flt = 1'b1; cse = 2'd0; wb = 1'b0; exp_pa = '0; upd = old;
        if (!oob) begin
            if (!old[0])             cse = 2'd1;
            else if (!wr && !old[1]) cse = 2'd2;
            else if (wr && !old[2])  cse = 2'd3;
            else                     flt = 1'b0;
            if (!flt) begin
                upd = old | 32'h8 | (wr ? 32'h10 : 32'h0);
                wb  = (upd != old);
                exp_pa = {old[31:12], va[11:0]};
            end
        end
        exp_lat = oob ? 1 : (3 + extra + (wb ? 1 : 0));

        @(negedge clk);
        rd0 = rd_total; wr0 = wr_total;
        mem_extra = extra;
        req_valid = 1'b1; req_va = va; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy_ready = 1'b0;
        while (!rsp_valid && lat < 40) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R10", "latency", lat, exp_lat);
        chk(!busy_ready, "R10", "ready while busy", {31'd0, busy_ready}, 0);
        chk(rsp_fault == flt, flt ? (oob ? "R4" : "R5/R6") : "R2", "fault",
            {31'd0, rsp_fault}, {31'd0, flt});
        if (flt) chk(rsp_cause == cse, cse == 2'd0 ? "R4" : (cse == 2'd1 ? "R5" : "R6"),
                     "cause", {30'd0, rsp_cause}, {30'd0, cse});
        chk(rsp_pa == exp_pa, "R2", "pa", rsp_pa, exp_pa);
        chk(rsp_va == va, "R11", "va", rsp_va, va);
        chk(rd_total - rd0 == (oob ? 0 : 1), oob ? "R4" : "R3", "read count",
            rd_total - rd0, oob ? 0 : 1);
        if (!oob) chk(last_rd_addr == ent, "R3", "entry address", last_rd_addr, ent);
        chk(wr_total - wr0 == (wb ? 1 : 0), flt ? "R8" : "R7", "write-back count",
            wr_total - wr0, wb ? 1 : 0);
        if (!oob) chk(mem[ent[11:2]] == upd, flt ? "R8" : "R7", "entry image",
                      mem[ent[11:2]], upd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready == 1'b1, "R1", "ready", {31'd0, req_ready}, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 0);
        chk(!mem_rd_en && !mem_wr_en, "R1", "mem idle", {30'd0, mem_rd_en, mem_wr_en}, 0);
        // R1/R4: zero length after reset gives a range fault
        xlate(32'h0000_0123, 1'b0, 0);

        // R9: user-mode writes are dropped, request still out of range
        cfg(1'b0, 1'b0, 32'h0000_0400);
        cfg(1'b0, 1'b1, 32'd16);
        xlate(32'h0000_0123, 1'b0, 0);

        cfg(1'b1, 1'b0, 32'h0000_0400);
        cfg(1'b1, 1'b1, 32'd16);
        poke(32'h400 + 4*0,  32'h1234_5007);
        poke(32'h400 + 4*1,  32'h0000_1006);
        poke(32'h400 + 4*2,  32'h0000_2005);
        poke(32'h400 + 4*3,  32'h0000_3003);
        poke(32'h400 + 4*4,  32'h0000_0000);
        poke(32'h400 + 4*5,  32'h0000_5085);
        poke(32'h400 + 4*15, 32'hABCD_E003);

        xlate(32'h0000_0ABC, 1'b0, 0); // R7: referenced set, write-back
        xlate(32'h0000_0ABC, 1'b0, 0); // R7: no change, no write-back
        xlate(32'h0000_0F00, 1'b1, 0); // R7: dirty set
        xlate(32'h0000_0F00, 1'b1, 0); // R7: no change
        xlate(32'h0000_1010, 1'b0, 0); // R5
        xlate(32'h0000_2020, 1'b0, 0); // R6 read denied
        xlate(32'h0000_3030, 1'b1, 0); // R6 write denied
        xlate(32'h0000_4040, 1'b1, 0); // R5 invalid outranks permissions
        xlate(32'h0000_5555, 1'b1, 0); // R6/R7 write without read, reserved bit kept
        xlate(32'h0000_FFFF, 1'b0, 3); // R10 slow memory, last in-range page
        xlate(32'h0001_0000, 1'b0, 0); // R4 first page past the end

        cfg(1'b0, 1'b1, 32'd0);        // R9 ignored user write
        xlate(32'h0000_F001, 1'b0, 1);

        cfg(1'b1, 1'b1, 32'h0010_0000); // R9 full-range length
        poke(32'h400 + 32'h3F_FFFC, 32'h7777_7007);
        xlate(32'hFFFF_F123, 1'b0, 0);

        cfg(1'b1, 1'b0, 32'h0000_0800); // R3 new base
        poke(32'h800, 32'h0004_2003);
        xlate(32'h0000_0777, 1'b0, 2);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule